// File: doc/BRIEF.md
# Outer Bank Register File with Protected CHR Latch

This block sits beside a banked memory controller for a cartridge-style system. It holds four 8-bit outer bank registers. The CPU writes them through the window from 0x6000 to 0x7FFF, and CPU address bits 1:0 choose which register is written. From these registers and the eight 1 KiB pattern-memory bank numbers supplied by the base controller, it forms a 10-bit 1 KiB bank number for each of the eight pattern windows of the picture unit.

Register 3 bit 7 is a lock that freezes registers 0, 1 and 3. Register 2 is a small latch that stays writable while the lock is set, but it guards some of its own bits against change. Register 3 bit 4 selects a whole-8 KiB mode. In that mode register 2 picks one 8 KiB bank for all eight windows and the base controller's 1 KiB numbers are ignored.

A parameter selects one of two board wirings for the two high outer bank bits. An asynchronous power-on reset and a synchronous soft reset both clear every register.

Top module: `chr_outer_bank_regs`

## Requirements
- R1: Asserting `rst_n` low, or sampling `soft_rst` high on a clock edge, clears all four registers to 0x00. Soft reset takes precedence over a write in the same cycle.
- R2: A register is written only on a rising clock edge where `cpu_wr` is high and `cpu_addr` lies in 0x6000..0x7FFF. `cpu_addr[1:0]` selects register 0..3. All other cycles leave every register unchanged.
- R3: While register 3 bit 7 is 1, writes that select register 0, 1 or 3 have no effect.
- R4: A write that selects register 2 is applied whether or not register 3 bit 7 is set.
- R5: When the current register 2 bit 7 is 1, a register 2 write leaves bits 6:4 unchanged.
- R6: For each n in 1..3, when the current register 2 bit (n+3) is 1, a register 2 write leaves bit n unchanged. All bits not guarded by R5 or R6 take the written data.
- R7: The inner mask is 0x07F when register 0 bit 7 is 1, and 0x0FF otherwise. With register 3 bit 4 at 0, each window outputs (its 8-bit input bank AND inner mask) OR (outer bank AND NOT inner mask).
- R8: With SWAP_HI = 0, the outer bank bits are: bit 7 = register 0 bit 3, bit 8 = register 0 bit 4, bit 9 = NOT register 0 bit 5. Outer bank bits 6:0 are zero.
- R9: With SWAP_HI = 1, the outer bank bits are: bit 7 = register 0 bit 3, bit 8 = NOT register 0 bit 5, bit 9 = register 0 bit 4.
- R10: With register 3 bit 4 at 1, window w (0..7) outputs 8*B + w, where B = (register 2 AND (inner mask >> 3)) OR ((outer bank AND NOT inner mask) >> 3). The window inputs have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| win_bank_in | input | 64 | Eight 8-bit 1 KiB bank numbers from the base controller; window w is at bits 8w+7:8w |
| outer_regs | output | 32 | Registers 0..3; register n is at bits 8n+7:8n |
| win_bank_out | output | 80 | Eight 10-bit 1 KiB bank numbers; window w is at bits 10w+9:10w |

## Verification
The assertions assume that `cpu_addr`, `cpu_data`, `cpu_wr` and `soft_rst` are stable around each rising edge. They also assume `rst_n` is low from time zero until the first edges have passed, so every `$past` term refers to a cycle after reset. The stimulus changes inputs only on falling edges and releases reset on a falling edge. The latch properties relate the register 2 value before a write to the value after it, so a soft reset in that cycle is excluded from their antecedents. The stimulus covers both cases. The whole-bank property checks only how the eight windows relate to each other, and the bench model checks their absolute values.

// File: rtl/obr_pkg.sv
package obr_pkg;

    typedef struct packed {
        logic [7:0] r3;
        logic [7:0] r2;
        logic [7:0] r1;
        logic [7:0] r0;
    } obr_regs_t;

    localparam int unsigned LOCK_BIT    = 7;
    localparam int unsigned WHOLE8K_BIT = 4;
    localparam int unsigned CHR128_BIT  = 7;
    localparam int unsigned LATCH_SEL   = 2;

endpackage

// File: rtl/obr_regfile.sv
module obr_regfile
    import obr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output obr_regs_t         regs_q
);

    obr_regs_t  regs_d;
    logic       hit;
    logic [1:0] sel;
    logic [7:0] keep;
    logic       locked;

    always_comb begin
        regs_d = regs_q;
        hit    = wr_en && (wr_addr >= WIN_BASE) && (wr_addr <= WIN_LAST);
        sel    = wr_addr[1:0];
        locked = regs_q.r3[LOCK_BIT];
        keep   = (regs_q.r2[7] ? 8'h70 : 8'h00)
               | {4'b0000, regs_q.r2[6:4], 1'b0};
        if (soft_rst) begin
            regs_d = '0;
        end else if (hit) begin
            case (sel)
                2'd0: if (!locked) regs_d.r0 = wr_data;
                2'd1: if (!locked) regs_d.r1 = wr_data;
                2'd2: regs_d.r2 = (regs_q.r2 & keep) | (wr_data & ~keep);
                default: if (!locked) regs_d.r3 = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/obr_outer.sv
module obr_outer #(
    parameter int unsigned BANK_W  = 10,
    parameter int unsigned SMALL_W = 7,
    parameter int unsigned LARGE_W = 8,
    parameter bit          SWAP_HI = 1'b0
) (
    input  logic              sel_lo,
    input  logic              sel_mid,
    input  logic              sel_hi,
    input  logic              chr_small,
    output logic [BANK_W-1:0] outer_bank,
    output logic [BANK_W-1:0] inner_mask
);

    localparam logic [BANK_W-1:0] MASK_SMALL = BANK_W'((1 << SMALL_W) - 1);
    localparam logic [BANK_W-1:0] MASK_LARGE = BANK_W'((1 << LARGE_W) - 1);
    localparam int unsigned       LOW_W      = BANK_W - 3;

    logic [2:0] top3;

    generate
        if (SWAP_HI) begin : g_swapped
            always_comb top3 = {sel_mid, ~sel_hi, sel_lo};
        end else begin : g_normal
            always_comb top3 = {~sel_hi, sel_mid, sel_lo};
        end
    endgenerate

    always_comb begin
        inner_mask = chr_small ? MASK_SMALL : MASK_LARGE;
        outer_bank = {top3, {LOW_W{1'b0}}};
    end

endmodule

// File: rtl/obr_chr_map.sv
module obr_chr_map #(
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned IN_W    = 8,
    parameter int unsigned BANK_W  = 10
) (
    input  logic [NUM_WIN*IN_W-1:0]   bank_in,
    input  logic [BANK_W-1:0]         outer_bank,
    input  logic [BANK_W-1:0]         inner_mask,
    input  logic                      whole_mode,
    input  logic [7:0]                latch_val,
    output logic [NUM_WIN*BANK_W-1:0] bank_out
);

    localparam int unsigned WIN_SH = $clog2(NUM_WIN);

    logic [BANK_W-1:0] outer_eff;
    logic [BANK_W-1:0] big_bank;

    always_comb begin
        outer_eff = outer_bank & ~inner_mask;
        big_bank  = (BANK_W'(latch_val) & (inner_mask >> WIN_SH))
                  | (outer_eff >> WIN_SH);
    end

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic [BANK_W-1:0] small_bank;
            always_comb begin
                small_bank = (BANK_W'(bank_in[w*IN_W +: IN_W]) & inner_mask) | outer_eff;
                bank_out[w*BANK_W +: BANK_W] = whole_mode
                    ? ((big_bank << WIN_SH) | BANK_W'(w))
                    : small_bank;
            end
        end
    endgenerate

endmodule

// File: rtl/chr_outer_bank_regs.sv
module chr_outer_bank_regs
    import obr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned IN_W    = 8,
    parameter int unsigned BANK_W  = 10,
    parameter bit          SWAP_HI = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      cpu_wr,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [7:0]                cpu_data,
    input  logic [NUM_WIN*IN_W-1:0]   win_bank_in,
    output logic [31:0]               outer_regs,
    output logic [NUM_WIN*BANK_W-1:0] win_bank_out
);

    obr_regs_t         regs_q;
    logic [BANK_W-1:0] outer_bank;
    logic [BANK_W-1:0] inner_mask;

    obr_regfile #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (cpu_wr),
        .wr_addr  (cpu_addr),
        .wr_data  (cpu_data),
        .regs_q   (regs_q)
    );

    obr_outer #(
        .BANK_W  (BANK_W),
        .SWAP_HI (SWAP_HI)
    ) u_outer (
        .sel_lo     (regs_q.r0[3]),
        .sel_mid    (regs_q.r0[4]),
        .sel_hi     (regs_q.r0[5]),
        .chr_small  (regs_q.r0[CHR128_BIT]),
        .outer_bank (outer_bank),
        .inner_mask (inner_mask)
    );

    obr_chr_map #(
        .NUM_WIN (NUM_WIN),
        .IN_W    (IN_W),
        .BANK_W  (BANK_W)
    ) u_map (
        .bank_in    (win_bank_in),
        .outer_bank (outer_bank),
        .inner_mask (inner_mask),
        .whole_mode (regs_q.r3[WHOLE8K_BIT]),
        .latch_val  (regs_q.r2),
        .bank_out   (win_bank_out)
    );

    assign outer_regs = regs_q;

endmodule

// File: rtl/chr_outer_bank_regs_chk.sv
module chr_outer_bank_regs_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_WIN = 8,
    parameter int unsigned BANK_W  = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      soft_rst,
    input logic                      cpu_wr,
    input logic [ADDR_W-1:0]         cpu_addr,
    input logic [31:0]               outer_regs,
    input logic [NUM_WIN*BANK_W-1:0] win_bank_out
);

    logic hit;
    logic to_latch;
    logic to_other;

    always_comb begin
        hit      = cpu_wr && (cpu_addr >= ADDR_W'(16'h6000)) && (cpu_addr <= ADDR_W'(16'h7FFF));
        to_latch = hit && !soft_rst && (cpu_addr[1:0] == 2'd2);
        to_other = hit && !soft_rst && (cpu_addr[1:0] != 2'd2);
    end

    p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (outer_regs == 32'h0));

    p_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !soft_rst) |=> $stable(outer_regs));

    p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (to_other && outer_regs[31]) |=> $stable(outer_regs));

    p_latch_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_latch && outer_regs[23]) |=> $stable(outer_regs[22:20]));

    p_latch_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        to_latch |=> (((outer_regs[19:17] ^ $past(outer_regs[19:17]))
                       & $past(outer_regs[22:20])) == 3'b000));

    generate
        for (genvar w = 1; w < NUM_WIN; w++) begin : g_win
            p_whole_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
                outer_regs[28] |->
                    ((win_bank_out[w*BANK_W +: BANK_W] - win_bank_out[BANK_W-1:0])
                     == BANK_W'(w)));
        end
    endgenerate

endmodule

bind chr_outer_bank_regs chr_outer_bank_regs_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_WIN (NUM_WIN),
    .BANK_W  (BANK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .outer_regs   (outer_regs),
    .win_bank_out (win_bank_out)
);

// File: tb/chr_outer_bank_regs_test.sv
`timescale 1ns/1ps
module chr_outer_bank_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_data = 8'h0;
    logic [63:0] win_bank_in = 64'h0;
    logic [31:0] regs_a, regs_b;
    logic [79:0] out_a, out_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mr[4];
    int seed = 12345;

    always #4 clk = ~clk;

    chr_outer_bank_regs #(.SWAP_HI(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .win_bank_in(win_bank_in),
        .outer_regs(regs_a), .win_bank_out(out_a));

    chr_outer_bank_regs #(.SWAP_HI(1'b1)) uut_swp (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .win_bank_in(win_bank_in),
        .outer_regs(regs_b), .win_bank_out(out_b));

    function automatic int bit_of(int v, int n);
        return (v >> n) & 1;
    endfunction

    function automatic int exp_win(bit swap, int w);
        int im;
        int ob;
        int inb;
        im = bit_of(mr[0], 7) ? 127 : 255;
        ob = bit_of(mr[0], 3) * 128;
        if (!swap) ob = ob + bit_of(mr[0], 4) * 256 + (1 - bit_of(mr[0], 5)) * 512;
        else       ob = ob + (1 - bit_of(mr[0], 5)) * 256 + bit_of(mr[0], 4) * 512;
        ob = ob & ~im & 1023;
        if (bit_of(mr[3], 4) == 1)
            return (((mr[2] & (im / 8)) | (ob / 8)) * 8 + w) & 1023;
        inb = int'(win_bank_in[w*8 +: 8]);
        return (inb & im) | ob;
    endfunction

    function automatic logic [79:0] exp_vec(bit swap);
        logic [79:0] v;
        for (int w = 0; w < 8; w++) v[w*10 +: 10] = 10'(exp_win(swap, w));
        return v;
    endfunction

    task automatic model_edge();
        int sel;
        int keep;
        if (soft_rst) begin
            for (int i = 0; i < 4; i++) mr[i] = 0;
        end else if (cpu_wr && cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF) begin
            sel = int'(cpu_addr) % 4;
            if (sel == 2) begin
                keep = (mr[2] >= 128 ? 'h70 : 0) | (((mr[2] >> 4) & 7) * 2);
                mr[2] = (mr[2] & keep) | (int'(cpu_data) & ~keep & 255);
            end else if (mr[3] < 128) begin
                mr[sel] = int'(cpu_data);
            end
        end
    endtask

    task automatic check(bit ok, string tag, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [31:0] er;
        logic [79:0] ea, eb;
        er = {8'(mr[3]), 8'(mr[2]), 8'(mr[1]), 8'(mr[0])};
        ea = exp_vec(1'b0);
        eb = exp_vec(1'b1);
        check(regs_a == er && regs_b == er, tag, "regs", {48'h0, regs_a}, {48'h0, er});
        check(out_a == ea, tag, "banks", out_a, ea);
        check(out_b == eb, tag, "banks_swapped", out_b, eb);
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cpu_wr   = 1'b0;
        soft_rst = 1'b0;
        compare(tag);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        cyc(tag);
    endtask

    task automatic sreset(string tag);
        soft_rst = 1'b1;
        cyc(tag);
    endtask

    function automatic int rnd();
        seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
        return seed >> 8;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mr[i] = 0;
        win_bank_in = 64'hF0E1_D2C3_B4A5_9687;
        repeat (2) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        cyc("R1");

        // R2: plain writes and ignored cycles
        wr(16'h6000, 8'h18, "R2");
        wr(16'h6001, 8'hA5, "R2");
        wr(16'h7FFE, 8'h03, "R2");
        wr(16'h5FFF, 8'hFF, "R2");
        wr(16'h8000, 8'hFF, "R2");
        wr(16'hE003, 8'hFF, "R2");
        cpu_addr = 16'h6000; cpu_data = 8'h77;
        cyc("R2");

        // R7, R8, R9: outer wiring and inner mask in 1 KiB mode
        wr(16'h6000, 8'h00, "R8");
        wr(16'h6000, 8'h20, "R8");
        wr(16'h6000, 8'h10, "R9");
        wr(16'h6000, 8'h38, "R9");
        wr(16'h6000, 8'h88, "R7");
        wr(16'h6000, 8'hB8, "R7");
        win_bank_in = 64'h00FF_7F80_1234_5678;
        cyc("R7");
        wr(16'h6000, 8'h08, "R8");
        cyc("R8");

        // R5, R6: self-guarded latch register
        sreset("R1");
        wr(16'h6002, 8'h80, "R5");
        wr(16'h6002, 8'hFF, "R5");
        wr(16'h6002, 8'h00, "R5");
        sreset("R1");
        wr(16'h6002, 8'h50, "R6");
        wr(16'h6002, 8'h0F, "R6");
        wr(16'h6002, 8'h20, "R6");
        wr(16'h6002, 8'h00, "R6");

        // R3, R4: lock behaviour
        sreset("R1");
        wr(16'h6000, 8'h11, "R3");
        wr(16'h6003, 8'h80, "R3");
        wr(16'h6000, 8'hEE, "R3");
        wr(16'h6001, 8'hEE, "R3");
        wr(16'h6003, 8'h00, "R3");
        wr(16'h6002, 8'h0C, "R4");
        wr(16'h7FFA, 8'h03, "R4");
        cpu_wr = 1'b1; cpu_addr = 16'h6001; cpu_data = 8'h44; soft_rst = 1'b1;
        cyc("R1");

        // R10: whole 8 KiB mode
        wr(16'h6003, 8'h10, "R10");
        wr(16'h6002, 8'h0B, "R10");
        wr(16'h6000, 8'h80, "R10");
        wr(16'h6000, 8'hB8, "R10");
        wr(16'h6000, 8'h28, "R10");
        win_bank_in = 64'h0123_4567_89AB_CDEF;
        cyc("R10");
        wr(16'h6002, 8'h1F, "R10");

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            cpu_wr   = (rnd() % 4) != 0;
            cpu_addr = 16'(((rnd() % 8) == 0) ? rnd() : (16'h6000 | (rnd() & 16'h1FFF)));
            cpu_data = 8'(rnd());
            soft_rst = (rnd() % 40) == 0;
            win_bank_in = {32'(rnd()), 32'(rnd())};
            cyc("R2");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule